// File: doc/BRIEF.md
# Sparse Symmetric Grey-Level Pair Histogram

This block builds a co-occurrence histogram of grey-level pairs for one fixed direction and distance. A pixel source upstream presents one pair of 5-bit grey levels per clock with a valid strobe. The block orders each pair so that the smaller level comes first, which folds mirrored pairs into one entry. It then counts that pair in a sparse store. The store is built as a set-associative tag array in front of a block of 16-bit counters, so cells exist only for pairs that actually occur.

Each pair passes through a four-stage update pipeline:
- read every way's tag in the pair's set;
- compare the tags, or claim a free way;
- read the counter;
- write back the count plus one.

Forwarding between stages lets back-to-back pairs that share a key or a set be counted without stalls. A clear command empties the store by sweeping one set per cycle, and input is refused while it runs. A scan port returns the occupancy, key and count of any cell, so the whole histogram can be read out address by address.

Top module: `cooc_sparse_hist`

## Requirements
- R1: A pair (a, b) is counted under the 10-bit key {min(a,b), max(a,b)}, with the smaller level in key bits 9:5. The pairs (a, b) and (b, a) therefore share one entry.
- R2: Each accepted pair increases the count of its key by one. The first occurrence of a key leaves a count of 1.
- R3: Key bits 3:0 select the set and key bits 9:4 form the tag. A cell address is {way, set}, with the way in bits 7:4 and the set in bits 3:0. A new key takes the lowest-numbered unoccupied way of its set.
- R4: Pairs accepted on consecutive cycles are all counted. This holds when they share a key, and when they share a set and each claims a new way. No key ever occupies two ways.
- R5: The counter write for a pair accepted at clock edge E lands on edge E+3. A scan read captured on edge E+3 still returns the previous count, and a scan read on edge E+4 returns the new count.
- R6: A new key whose set already holds 16 keys is dropped and raises ovf_o. ovf_o stays high until a clear, and the keys already stored keep counting.
- R7: Counts saturate at 65535 and further pairs leave them there.
- R8: A pulse on clr_i drops ready_o for exactly 16 cycles and discards pairs still in flight. Afterwards every cell reads as unoccupied and ovf_o is 0. Pairs presented while ready_o is low are ignored.
- R9: After reset ready_o is 1, ovf_o is 0 and no cell is occupied.
- R10: scan_vld_o is high one cycle after scan_en_i. In that cycle scan_hit_o, scan_key_o ({stored tag, set}) and scan_cnt_o describe the cell at the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear pulse: empty the histogram |
| pix_vld_i | input | 1 | Pair valid strobe |
| pix_a_i | input | 5 | First grey level of the pair |
| pix_b_i | input | 5 | Second grey level of the pair |
| ready_o | output | 1 | High when pairs are accepted |
| ovf_o | output | 1 | Sticky flag: a new key found its set full |
| scan_en_i | input | 1 | Scan read request |
| scan_addr_i | input | 8 | Scan cell address {way, set} |
| scan_vld_o | output | 1 | Scan result valid |
| scan_hit_o | output | 1 | Scanned cell is occupied |
| scan_key_o | output | 10 | Key stored in the scanned cell |
| scan_cnt_o | output | 16 | Count stored in the scanned cell |

## Verification
The main stream mixes mirrored pairs, a key repeated on adjacent cycles and two new keys sharing a set on adjacent cycles. Together these separate a missing normalisation, a lost increment from a stale counter read, and a duplicate allocation from a stale tag snapshot. A single pair is then watched with a scan on every edge, which pins the write to the exact edge. Filling one set with seventeen distinct keys in back-to-back cycles checks lowest-free-way allocation and the overflow drop. A long run of one key checks saturation, and a clear with traffic held at the input checks the sweep length and that the refused pairs leave no trace.

// File: rtl/cooc_pkg.sv
package cooc_pkg;
  localparam int unsigned LVL_W_DEF = 5;
  localparam int unsigned WAYS_DEF  = 16;
  localparam int unsigned CELLS_DEF = 256;
  localparam int unsigned CNT_W_DEF = 16;

  typedef enum logic {
    CTL_RUN   = 1'b0,
    CTL_SWEEP = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cooc_way_match.sv
module cooc_way_match #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned WAY_W = 4
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            occ_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  logic [WAYS-1:0] match_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = occ_i[w] && (tags_i[w] == tag_i);
  end

  // priority: the lowest-numbered way wins, so scan from the top down
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (!occ_i[w]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cooc_tag_store.sv
module cooc_tag_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 16,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned SET_W = 4,
  parameter int unsigned WAY_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sweep_i,
  input  logic [SET_W-1:0]           sweep_set_i,
  input  logic [SET_W-1:0]           rd_set_i,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tags_o,
  output logic [WAYS-1:0]            rd_occ_o,
  input  logic                       wr_en_i,
  input  logic [SET_W-1:0]           wr_set_i,
  input  logic [WAY_W-1:0]           wr_way_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic [SET_W-1:0]           scan_set_i,
  input  logic [WAY_W-1:0]           scan_way_i,
  output logic                       scan_occ_o,
  output logic [TAG_W-1:0]           scan_tag_o
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            occ_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) occ_q[s] <= '0;
    end else if (sweep_i) begin
      occ_q[sweep_set_i] <= '0;
    end else if (wr_en_i) begin
      occ_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end

  assign rd_tags_o  = tag_q[rd_set_i];
  assign rd_occ_o   = occ_q[rd_set_i];
  assign scan_occ_o = occ_q[scan_set_i][scan_way_i];
  assign scan_tag_o = tag_q[scan_set_i][scan_way_i];

  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (occ_q[wr_set_i][w] && (tag_q[wr_set_i][w] == wr_tag_i)) dup_tag = 1'b1;
    end
  end

  AST_ALLOC_FREE_WAY: assert property (@(posedge clk) disable iff (rst) wr_en_i |-> !occ_q[wr_set_i][wr_way_i]) else $error("allocation into occupied way"); // R3
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (rst) wr_en_i |-> !dup_tag) else $error("key allocated twice"); // R4
  AST_SWEEP_EXCL: assert property (@(posedge clk) disable iff (rst) sweep_i |-> !wr_en_i) else $error("allocation during sweep"); // R8
endmodule

// File: rtl/cooc_count_ram.sv
module cooc_count_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] scan_addr_i,
  output logic [DW-1:0] scan_data_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    rd_data_o   <= mem[rd_addr_i];
    scan_data_o <= mem[scan_addr_i];
  end
endmodule

// File: rtl/cooc_sparse_hist.sv
module cooc_sparse_hist
  import cooc_pkg::*;
#(
  parameter int unsigned LVL_W = LVL_W_DEF,
  parameter int unsigned WAYS  = WAYS_DEF,
  parameter int unsigned CELLS = CELLS_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_i,
  input  logic                          pix_vld_i,
  input  logic [LVL_W-1:0]              pix_a_i,
  input  logic [LVL_W-1:0]              pix_b_i,
  output logic                          ready_o,
  output logic                          ovf_o,
  input  logic                          scan_en_i,
  input  logic [$clog2(CELLS)-1:0]      scan_addr_i,
  output logic                          scan_vld_o,
  output logic                          scan_hit_o,
  output logic [2*LVL_W-1:0]            scan_key_o,
  output logic [CNT_W-1:0]              scan_cnt_o
);
  localparam int unsigned KEY_W  = 2 * LVL_W;
  localparam int unsigned SETS   = CELLS / WAYS;
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned TAG_W  = KEY_W - SET_W;
  localparam int unsigned ADDR_W = $clog2(CELLS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // ---------------- control: clear sweep ----------------
  ctl_state_e       st_q;
  logic [SET_W-1:0] sweep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CTL_RUN;
      sweep_q <= '0;
    end else if (clr_i) begin
      st_q    <= CTL_SWEEP;
      sweep_q <= '0;
    end else if (st_q == CTL_SWEEP) begin
      if (sweep_q == SET_W'(SETS - 1)) st_q <= CTL_RUN;
      sweep_q <= sweep_q + 1'b1;
    end
  end

  assign ready_o = (st_q == CTL_RUN);

  // ---------------- input normalisation ----------------
  logic             accept;
  logic [LVL_W-1:0] lvl_lo, lvl_hi;
  logic [KEY_W-1:0] key_in;
  logic [SET_W-1:0] set_in;
  logic [TAG_W-1:0] tag_in;

  assign accept = pix_vld_i && ready_o;
  assign lvl_lo = (pix_a_i <= pix_b_i) ? pix_a_i : pix_b_i;
  assign lvl_hi = (pix_a_i <= pix_b_i) ? pix_b_i : pix_a_i;
  assign key_in = {lvl_lo, lvl_hi};
  assign set_in = key_in[SET_W-1:0];
  assign tag_in = key_in[KEY_W-1:SET_W];

  // ---------------- tag store ----------------
  logic [WAYS-1:0][TAG_W-1:0] rd_tags;
  logic [WAYS-1:0]            rd_occ;
  logic                       alloc_en;
  logic [WAY_W-1:0]           free_way, hit_way;
  logic                       hit, free;
  logic                       scan_occ;
  logic [TAG_W-1:0]           scan_tag;

  logic                       s1_v;
  logic [SET_W-1:0]           s1_set;
  logic [TAG_W-1:0]           s1_tag;
  logic [WAYS-1:0][TAG_W-1:0] s1_tags;
  logic [WAYS-1:0]            s1_occ;

  cooc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk        (clk),
    .rst        (rst),
    .sweep_i    (st_q == CTL_SWEEP),
    .sweep_set_i(sweep_q),
    .rd_set_i   (set_in),
    .rd_tags_o  (rd_tags),
    .rd_occ_o   (rd_occ),
    .wr_en_i    (alloc_en),
    .wr_set_i   (s1_set),
    .wr_way_i   (free_way),
    .wr_tag_i   (s1_tag),
    .scan_set_i (scan_addr_i[SET_W-1:0]),
    .scan_way_i (scan_addr_i[ADDR_W-1:SET_W]),
    .scan_occ_o (scan_occ),
    .scan_tag_o (scan_tag)
  );

  // stage 1: snapshot the set, patched with an allocation landing this cycle
  logic [WAYS-1:0][TAG_W-1:0] snap_tags;
  logic [WAYS-1:0]            snap_occ;

  always_comb begin
    snap_tags = rd_tags;
    snap_occ  = rd_occ;
    if (alloc_en && (s1_set == set_in)) begin
      snap_tags[free_way] = s1_tag;
      snap_occ[free_way]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= accept && !clr_i;
    s1_set  <= set_in;
    s1_tag  <= tag_in;
    s1_tags <= snap_tags;
    s1_occ  <= snap_occ;
  end

  // stage 2: compare and allocate
  cooc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .tags_i    (s1_tags),
    .occ_i     (s1_occ),
    .tag_i     (s1_tag),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .free_o    (free),
    .free_way_o(free_way)
  );

  assign alloc_en = s1_v && !hit && free;

  logic              s2_v, s2_fresh;
  logic [ADDR_W-1:0] s2_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v  <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      s2_v <= s1_v && (hit || free) && !clr_i;
      if (clr_i)                        ovf_o <= 1'b0;
      else if (s1_v && !hit && !free)   ovf_o <= 1'b1;
    end
    s2_addr  <= {(hit ? hit_way : free_way), s1_set};
    s2_fresh <= !hit;
  end

  // stage 3: counter read; stage 4: saturating write-back
  logic              s3_v, s3_fresh, s3_byp;
  logic [ADDR_W-1:0] s3_addr;
  logic [CNT_W-1:0]  s3_bypval, ram_rd, cnt_cur, cnt_upd, scan_cnt;

  assign cnt_cur = s3_fresh ? '0 : (s3_byp ? s3_bypval : ram_rd);
  assign cnt_upd = (cnt_cur == CNT_MAX) ? cnt_cur : cnt_cur + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) s3_v <= 1'b0;
    else     s3_v <= s2_v && !clr_i;
    s3_addr   <= s2_addr;
    s3_fresh  <= s2_fresh;
    s3_byp    <= s3_v && (s3_addr == s2_addr);
    s3_bypval <= cnt_upd;
  end

  cooc_count_ram #(.DEPTH(CELLS), .AW(ADDR_W), .DW(CNT_W)) u_cnt (
    .clk        (clk),
    .rd_addr_i  (s2_addr),
    .rd_data_o  (ram_rd),
    .wr_en_i    (s3_v),
    .wr_addr_i  (s3_addr),
    .wr_data_i  (cnt_upd),
    .scan_addr_i(scan_addr_i),
    .scan_data_o(scan_cnt)
  );

  // ---------------- scan port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_vld_o <= 1'b0;
      scan_hit_o <= 1'b0;
      scan_key_o <= '0;
    end else begin
      scan_vld_o <= scan_en_i;
      if (scan_en_i) begin
        scan_hit_o <= scan_occ;
        scan_key_o <= {scan_tag, scan_addr_i[SET_W-1:0]};
      end
    end
  end

  assign scan_cnt_o = scan_cnt;

  AST_CLR_DROPS_READY: assert property (@(posedge clk) disable iff (rst) clr_i |=> !ready_o) else $error("ready high after clear"); // R8
  AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (rst) s3_v |-> $past(accept, 3)) else $error("write without pair three cycles back"); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_o && !clr_i) |=> ovf_o) else $error("overflow flag lost"); // R6
  AST_NO_ACCEPT_SWEEP: assert property (@(posedge clk) disable iff (rst) (st_q == CTL_SWEEP) |=> !s1_v) else $error("pair accepted during sweep"); // R8
endmodule

// File: tb/cooc_sparse_hist_bench.sv
module cooc_sparse_hist_bench;
  logic        clk = 1'b0;
  logic        rst, clr, pix_vld, scan_en;
  logic [4:0]  pix_a, pix_b;
  logic [7:0]  scan_addr;
  logic        ready, ovf, scan_vld, scan_hit;
  logic [9:0]  scan_key;
  logic [15:0] scan_cnt;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  cooc_sparse_hist u_cooc_sparse_hist (
    .clk(clk), .rst(rst), .clr_i(clr), .pix_vld_i(pix_vld),
    .pix_a_i(pix_a), .pix_b_i(pix_b), .ready_o(ready), .ovf_o(ovf),
    .scan_en_i(scan_en), .scan_addr_i(scan_addr), .scan_vld_o(scan_vld),
    .scan_hit_o(scan_hit), .scan_key_o(scan_key), .scan_cnt_o(scan_cnt)
  );

  localparam int NPAIR = 8;
  localparam logic [9:0] PAIRS [NPAIR] = '{
    {5'd3, 5'd7}, {5'd0, 5'd7}, {5'd7, 5'd3}, {5'd3, 5'd7},
    {5'd7, 5'd0}, {5'd31, 5'd31}, {5'd31, 5'd31}, {5'd2, 5'd2}
  };
  // {addr, hit, key, count}
  localparam int NEXP = 5;
  localparam logic [34:0] EXPS [NEXP] = '{
    {8'h07, 1'b1, 10'd103,  16'd3},
    {8'h17, 1'b1, 10'd7,    16'd2},
    {8'h0F, 1'b1, 10'd1023, 16'd2},
    {8'h02, 1'b1, 10'd66,   16'd1},
    {8'h27, 1'b0, 10'd0,    16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    pix_vld = 1'b1;
    pix_a   = a;
    pix_b   = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    pix_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic scan(input logic [7:0] a);
    @(negedge clk);
    scan_en   = 1'b1;
    scan_addr = a;
    @(negedge clk);
    scan_en   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int hits528;
    int lows;
    rst = 1'b1; clr = 1'b0; pix_vld = 1'b0; pix_a = '0; pix_b = '0;
    scan_en = 1'b0; scan_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 ready", 32'(ready), 1);
    chk("R9 ovf", 32'(ovf), 0);
    scan(8'h00);
    chk("R10 scan valid", 32'(scan_vld), 1);
    chk("R9 empty cell", 32'(scan_hit), 0);

    // table-driven stream, back to back
    for (int i = 0; i < NPAIR; i++) push(PAIRS[i][9:5], PAIRS[i][4:0]);
    idle(6);
    for (int i = 0; i < NEXP; i++) begin
      scan(EXPS[i][34:27]);
      chk("R3 occupancy", 32'(scan_hit), 32'(EXPS[i][26]));
      if (EXPS[i][26]) begin
        chk("R1 key", 32'(scan_key), 32'(EXPS[i][25:16]));
        chk("R4 count", 32'(scan_cnt), 32'(EXPS[i][15:0]));
      end
    end

    // R2 one more increment
    push(5'd2, 5'd2);
    idle(6);
    scan(8'h02);
    chk("R2 increment", 32'(scan_cnt), 2);

    // R5 exact write edge
    push(5'd7, 5'd3);
    @(negedge clk);
    pix_vld = 1'b0; scan_en = 1'b1; scan_addr = 8'h07;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk("R5 before write", 32'(scan_cnt), 3);
      if (k == 4) chk("R5 after write", 32'(scan_cnt), 4);
    end
    scan_en = 1'b0;

    // R6 fill set 0 with 16 keys, then a 17th
    for (int t = 1; t <= 31; t += 2) push(5'((t - 1) / 2), 5'd16);
    idle(6);
    chk("R6 no overflow at 16", 32'(ovf), 0);
    scan(8'hF0);
    chk("R3 sixteenth way key", 32'(scan_key), 496);
    push(5'd16, 5'd16);
    idle(6);
    chk("R6 overflow raised", 32'(ovf), 1);
    push(5'd0, 5'd16);
    idle(6);
    chk("R6 overflow sticky", 32'(ovf), 1);
    scan(8'h00);
    chk("R6 stored key counts", 32'(scan_cnt), 2);
    hits528 = 0;
    for (int w = 0; w < 16; w++) begin
      scan(8'(w * 16));
      if (scan_hit && scan_key == 10'd528) hits528++;
    end
    chk("R6 dropped key absent", 32'(hits528), 0);

    // R8 clear with traffic held at the input
    @(negedge clk);
    clr = 1'b1; pix_vld = 1'b1; pix_a = 5'd1; pix_b = 5'd1;
    @(negedge clk);
    clr = 1'b0;
    lows = 0;
    while (!ready && lows < 100) begin
      lows++;
      @(negedge clk);
    end
    pix_vld = 1'b0;
    chk("R8 sweep length", 32'(lows), 16);
    chk("R8 overflow cleared", 32'(ovf), 0);
    idle(6);
    scan(8'h07);
    chk("R8 cell emptied", 32'(scan_hit), 0);
    scan(8'h01);
    chk("R8 refused pair ignored", 32'(scan_hit), 0);
    scan(8'h00);
    chk("R8 set 0 emptied", 32'(scan_hit), 0);

    // R7 saturation
    for (int i = 0; i < 65540; i++) push(5'd5, 5'd9);
    idle(6);
    scan(8'h09);
    chk("R7 key", 32'(scan_key), 169);
    chk("R7 saturated", 32'(scan_cnt), 65535);
    push(5'd9, 5'd5);
    idle(6);
    scan(8'h09);
    chk("R7 stays saturated", 32'(scan_cnt), 65535);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule